// File: doc/BRIEF.md
# Selectable pin interrupt controller

This block turns chosen GPIO pins into interrupt requests. It watches a 64-bit input bus made of two 32-pin ports. Eight independent channels each pick one pin from that bus. Each channel has its own sensitivity setting and its own interrupt output. A channel runs in one of two modes:

- Edge mode, where it reacts to rising edges, falling edges or both. An edge is held as a sticky pending event until software acknowledges it.
- Level mode, where its output simply follows the selected pin at the chosen polarity.

All pins pass through a synchronizer before any channel sees them. A channel's configuration is set with a single write to that channel's address. A per-channel clear strobe acknowledges pending edge events. Each channel also drives a wake-up output. The wake-up enable for that output is independent of the interrupt enable.

Top module: `pinint_ctrl`

## Requirements
- R1: There are 8 channels. Channel n is configured at address n and drives only bit n of `irq_o` and bit n of `wake_o`.
- R2: The configuration word has these fields:
  - bits [5:0]: the pin index. Values 0..31 select `gpio_i[31:0]` (port 0) and values 32..63 select `gpio_i[63:32]` (port 1).
  - bit 6: mode, 1 = level, 0 = edge.
  - bit 7: in edge mode, the rising-edge enable; in level mode, the polarity (1 = high-active, 0 = low-active).
  - bit 8: the falling-edge enable in edge mode.
  - bit 9: the interrupt enable.
  - bit 10: the wake-up enable.
- R3: Each pin passes through a two-flop synchronizer. A pin value driven before clock edge k reaches a level-mode output after edge k+1. An edge on that pin sets the pending event at edge k+2.
- R4: In edge mode, the rising and falling enables act independently. A transition in a disabled direction does not set the pending event.
- R5: In edge mode, a pending event stays set until a cycle with that channel's `clr_i` bit high. If a new enabled edge is detected in that same cycle, the event stays set.
- R6: In level mode, the channel is active exactly while the synchronized pin equals the polarity. Nothing is latched, and `clr_i` has no effect.
- R7: `irq_o[n]` is the channel's active state ANDed with its interrupt enable. `wake_o[n]` is the active state ANDed with its wake-up enable, independently of the interrupt enable.
- R8: A write to a channel clears its pending event and its edge history. The next cycle only reloads the history, so changing the pin or mode never produces an edge.
- R9: After reset, every configuration word is zero, and `irq_o` and `wake_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 64 | Asynchronous pin inputs, port 1 in the upper half |
| we_i | input | 1 | Configuration write strobe |
| addr_i | input | 3 | Channel number written |
| wdata_i | input | 11 | Configuration word |
| clr_i | input | 8 | Per-channel acknowledge of pending edge events |
| irq_o | output | 8 | Per-channel interrupt requests |
| wake_o | output | 8 | Per-channel wake-up requests |

## Verification
The assertions assume `clr_i` and the write port are synchronous to `clk_i`. They also assume that `addr_i` is meaningful only while `we_i` is high. The stimulus meets both conditions: it changes every input, `gpio_i` included, on the falling edge. It also writes only complete configuration words to channels 0 to 7. Within that, the random phase writes any field value, including level mode with random edge-enable bits. It asserts clear strobes in both modes and toggles sparse pin subsets, so edges, clears and reconfigurations coincide in the same cycle.

// File: rtl/pinint_pkg.sv
package pinint_pkg;
  localparam int unsigned NUM_CH  = 8;
  localparam int unsigned NUM_PIN = 64;
  localparam int unsigned SEL_W   = $clog2(NUM_PIN);

  typedef struct packed {
    logic             wake_en;
    logic             irq_en;
    logic             fall_en;
    logic             rise_hi;   // rising enable (edge) / polarity (level)
    logic             lvl;
    logic [SEL_W-1:0] sel;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/pinint_sync.sv
module pinint_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pinint_cfg.sv
module pinint_cfg
  import pinint_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  ch_cfg_t             wdata_i,
  output ch_cfg_t [NCH-1:0]   cfg_o,
  output logic    [NCH-1:0]   wr_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_reg
    assign wr_o[c] = we_i && (addr_i == AW'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cfg_o[c] <= '0;
      else if (wr_o[c]) cfg_o[c] <= wdata_i;
    end
  end
endmodule

// File: rtl/pinint_chan.sv
module pinint_chan
  import pinint_pkg::*;
#(
  parameter int unsigned NPIN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ch_cfg_t         cfg_i,
  input  logic            wr_i,
  input  logic            clr_i,
  input  logic [NPIN-1:0] pins_i,
  output logic            irq_o,
  output logic            wake_o,
  output logic            pend_o,
  output logic            edge_o
);
  logic cur, prev_q, vld_q, pend_q, act;

  assign cur = pins_i[cfg_i.sel];

  // history is ignored for one cycle after any write (R8)
  assign edge_o = vld_q && !wr_i && !cfg_i.lvl &&
                  ((cfg_i.rise_hi && cur && !prev_q) ||
                   (cfg_i.fall_en && !cur && prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= cur;
      vld_q  <= 1'b1;
      pend_q <= cfg_i.lvl ? 1'b0 : (edge_o || (pend_q && !clr_i));
    end
  end

  assign act    = cfg_i.lvl ? (cur == cfg_i.rise_hi) : pend_q;
  assign irq_o  = act && cfg_i.irq_en;
  assign wake_o = act && cfg_i.wake_en;
  assign pend_o = pend_q;
endmodule

// File: rtl/pinint_ctrl.sv
module pinint_ctrl
  import pinint_pkg::*;
#(
  parameter int unsigned NUM_CH      = pinint_pkg::NUM_CH,
  parameter int unsigned NUM_PIN     = pinint_pkg::NUM_PIN,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PIN-1:0] gpio_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [CFG_W-1:0]   wdata_i,
  input  logic [NUM_CH-1:0]  clr_i,
  output logic [NUM_CH-1:0]  irq_o,
  output logic [NUM_CH-1:0]  wake_o
);
  logic [NUM_PIN-1:0]       pins_s;
  ch_cfg_t [NUM_CH-1:0]     cfg;
  logic    [NUM_CH-1:0]     wr;
  logic    [NUM_CH-1:0]     pend;
  logic    [NUM_CH-1:0]     edge_det;
  logic    [NUM_CH-1:0]     lvl_mode;

  pinint_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pins_s)
  );

  pinint_cfg #(.NCH(NUM_CH)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(ch_cfg_t'(wdata_i)),
    .cfg_o  (cfg),
    .wr_o   (wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign lvl_mode[c] = cfg[c].lvl;
    pinint_chan #(.NPIN(NUM_PIN)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg[c]),
      .wr_i  (wr[c]),
      .clr_i (clr_i[c]),
      .pins_i(pins_s),
      .irq_o (irq_o[c]),
      .wake_o(wake_o[c]),
      .pend_o(pend[c]),
      .edge_o(edge_det[c])
    );
  end
endmodule

// File: rtl/pinint_ctrl_chk.sv
module pinint_ctrl_chk #(
  parameter int unsigned NCH = 8,
  localparam int unsigned AW = $clog2(NCH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           we_i,
  input logic [AW-1:0]  addr_i,
  input logic [NCH-1:0] clr_i,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] edge_det,
  input logic [NCH-1:0] lvl_mode
);
  for (genvar c = 0; c < NCH; c++) begin : g_p
    // R8
    wr_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == AW'(c)) |=> !pend[c]);
    // R5
    clr_drops_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !edge_det[c]) |=> !pend[c]);
    // R5
    pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[c] && !clr_i[c] && !(we_i && addr_i == AW'(c))) |=> pend[c]);
    // R4
    edge_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_det[c] |=> pend[c]);
    // R6
    lvl_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_mode[c] |-> !pend[c]);
  end
endmodule

bind pinint_ctrl pinint_ctrl_chk #(.NCH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .clr_i   (clr_i),
  .pend    (pend),
  .edge_det(edge_det),
  .lvl_mode(lvl_mode)
);

// File: tb/tb_pinint_ctrl.sv
module tb_pinint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] gpio = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [10:0] wdata = '0;
  logic [7:0]  clr = '0;
  logic [7:0]  irq, wake;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pinint_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .clr_i(clr), .irq_o(irq), .wake_o(wake)
  );

  // reference model built from the requirements
  logic [63:0] m_s1, m_s2;
  logic [10:0] m_cfg [8];
  logic        m_prev [8], m_vld [8], m_pend [8];

  function automatic logic m_cur(int c);
    return m_s2[m_cfg[c][5:0]];
  endfunction

  function automatic logic m_edge(int c);
    logic cu = m_cur(c);
    if (!m_vld[c] || m_cfg[c][6]) return 1'b0;
    return (m_cfg[c][7] && cu && !m_prev[c]) || (m_cfg[c][8] && !cu && m_prev[c]);
  endfunction

  function automatic logic m_act(int c);
    return m_cfg[c][6] ? (m_cur(c) == m_cfg[c][7]) : m_pend[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0;
      for (int c = 0; c < 8; c++) begin
        m_cfg[c] <= '0; m_prev[c] <= 1'b0; m_vld[c] <= 1'b0; m_pend[c] <= 1'b0;
      end
    end else begin
      m_s1 <= gpio;
      m_s2 <= m_s1;
      for (int c = 0; c < 8; c++) begin
        if (we && addr == 3'(c)) begin
          m_cfg[c] <= wdata; m_prev[c] <= 1'b0; m_vld[c] <= 1'b0; m_pend[c] <= 1'b0;
        end else begin
          m_prev[c] <= m_cur(c);
          m_vld[c]  <= 1'b1;
          m_pend[c] <= m_cfg[c][6] ? 1'b0 : (m_edge(c) || (m_pend[c] && !clr[c]));
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 8; c++) begin
        chk(m_cfg[c][6] ? "R6 level irq" : "R5 edge irq", 32'(irq[c]),
            32'(m_act(c) && m_cfg[c][9]));
        chk("R7 wake", 32'(wake[c]), 32'(m_act(c) && m_cfg[c][10]));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, logic [10:0] d);
    @(negedge clk); we = 1'b1; addr = 3'(ch); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic logic [10:0] cfgw(bit wk, bit ie, bit fe, bit rh, bit lv, int sel);
    return {wk, ie, fe, rh, lv, 6'(sel)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9
    chk("R9 irq after reset", 32'(irq), 0);
    chk("R9 wake after reset", 32'(wake), 0);

    // R2 R3 R1: rising edge on port-1 pin 40
    wr(0, cfgw(1, 1, 0, 1, 0, 40));
    gpio[40] = 1'b1;
    tick(2);
    chk("R3 not yet pending", 32'(irq), 0);
    tick(1);
    chk("R1 R2 R3 only channel 0 fires", 32'(irq), 32'h01);
    chk("R7 wake channel 0", 32'(wake), 32'h01);

    // R4 falling ignored when disabled, event stays sticky
    gpio[40] = 1'b0;
    tick(4);
    chk("R4 fall disabled, R5 sticky", 32'(irq[0]), 1);
    // R5 clear coincides with a new edge
    gpio[40] = 1'b1;
    tick(2);
    clr[0] = 1'b1;
    tick(1);
    clr[0] = 1'b0;
    chk("R5 edge wins over clear", 32'(irq[0]), 1);
    clr[0] = 1'b1; tick(1); clr[0] = 1'b0;
    chk("R5 clear drops event", 32'(irq[0]), 0);

    // R4 falling-only channel
    wr(1, cfgw(0, 1, 1, 0, 0, 3));
    gpio[3] = 1'b1;
    tick(4);
    chk("R4 rise disabled", 32'(irq[1]), 0);
    gpio[3] = 1'b0;
    tick(3);
    chk("R4 fall detected", 32'(irq[1]), 1);
    chk("R7 wake disabled", 32'(wake[1]), 0);
    clr[1] = 1'b1; tick(1); clr[1] = 1'b0;

    // R6 low-active level mode
    wr(2, cfgw(0, 1, 0, 0, 1, 7));
    chk("R6 low level active", 32'(irq[2]), 1);
    clr[2] = 1'b1; tick(1); clr[2] = 1'b0;
    chk("R6 clear ignored", 32'(irq[2]), 1);
    gpio[7] = 1'b1;
    tick(1);
    chk("R3 level latency", 32'(irq[2]), 1);
    tick(1);
    chk("R6 level follows pin", 32'(irq[2]), 0);

    // R8 reselecting a high pin raises no edge
    gpio[11] = 1'b1;
    wr(3, cfgw(0, 1, 0, 1, 0, 10));
    tick(3);
    wr(3, cfgw(0, 1, 0, 1, 0, 11));
    tick(4);
    chk("R8 no edge on reselect", 32'(irq[3]), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      gpio ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      we = ($urandom % 12) == 0;
      addr = 3'($urandom);
      wdata = 11'($urandom);
      clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
    end
    @(negedge clk);
    we = 1'b0; clr = '0;
    tick(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule